// File: doc/BRIEF.md
# PCI Target Window Decoder

This block decides whether a PCI target claims an inbound transaction and, when it does, rewrites the bus address into the local address space. It keeps two independent windows. One serves memory transactions and one serves I/O transactions. Each window holds three registers:

- a size mask, written by the local core;
- a local base pointer, also written by the core;
- a base address register (BAR), written by the PCI host while it configures the device.

The mask should be one run of ones that starts at the top bit and runs downward. Its set bits are the only BAR bits the host can change, so the number of set bits fixes the window size. A window whose mask is all zero is disabled.

For each presented address, the block compares the masked address bits with the BAR. On a match it swaps those upper bits for the pointer's upper bits and passes the low bits through unchanged. The result appears one cycle after the request. A registered readback port lets either side inspect any of the six registers.

Top module: `pci_window_decode`

## Requirements
- R1: After reset, every mask, pointer and BAR reads back as zero, and no request is claimed.
- R2: A host BAR write changes only the bit positions set in that window's mask. BAR readback returns zero in every position where the mask is zero.
- R3: A window whose mask is zero never claims a request, even when the address equals its BAR.
- R4: A request hits a window only when three conditions hold: its type matches the window (`req_is_io`=0 memory, 1 I/O), the window mask is non-zero, and (addr AND mask) equals (BAR AND mask). At most one of `hit_mem`/`hit_io` is ever set, and `hit` is their OR.
- R5: On a hit, `local_addr` equals (pointer AND mask) OR (addr AND NOT mask). On a miss it is zero.
- R6: Pointer bits in positions where the mask is zero have no effect on `local_addr`. The pointer write still stores the full value, which reads back unchanged.
- R7: A core write to a mask clears every BAR bit that the new mask does not cover. Bits cleared this way stay zero if the mask later widens again.
- R8: Lookup results appear exactly one clock after the request. When `req_valid` is low, the next cycle shows `hit`, `hit_mem` and `hit_io` low.
- R9: Readback is registered, one cycle after the select. `rd_win` 0 selects the memory window and 1 selects the I/O window. `rd_sel` 0 selects the mask, 1 the pointer, 2 the BAR, and 3 returns zero.
- R10: When a core mask write and a host BAR write reach the same window in the same cycle, the BAR takes the host data gated by the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_wr_en | input | 1 | Core register write strobe |
| core_wr_win | input | 1 | Core write window: 0 memory, 1 I/O |
| core_wr_ptr | input | 1 | Core write target: 0 mask, 1 pointer |
| core_wr_data | input | ADDR_W | Core write data |
| host_bar_wr_en | input | 1 | Host BAR write strobe |
| host_bar_win | input | 1 | Host BAR window: 0 memory, 1 I/O |
| host_bar_data | input | ADDR_W | Host BAR write data |
| rd_win | input | 1 | Readback window select |
| rd_sel | input | 2 | Readback register select |
| rd_data | output | ADDR_W | Registered readback value |
| req_valid | input | 1 | Lookup request valid |
| req_is_io | input | 1 | Request type: 0 memory, 1 I/O |
| req_addr | input | ADDR_W | Incoming bus address |
| hit | output | 1 | Request claimed by either window |
| hit_mem | output | 1 | Memory window claimed the request |
| hit_io | output | 1 | I/O window claimed the request |
| local_addr | output | ADDR_W | Translated local address, zero on miss |

## Verification
The bench programs the memory BAR while the mask is still zero, so that BAR and address agree trivially. A decoder that skipped the non-zero-mask gate would then claim address zero. Pointer values carry junk in their low bits: a translator that did not mask the pointer would corrupt the offset. The mask is shrunk and then widened again, so a design that kept stale BAR bits would claim the old, larger range. The bench also sends an I/O request that carries a valid memory address; a window that ignored the type would claim it. Finally, a same-cycle mask write and BAR write would leave stray BAR bits if the new mask were not used as the gate.

// File: rtl/pci_win_pkg.sv
package pci_win_pkg;
  localparam int NUM_WIN = 2;
  localparam int WIN_MEM = 0;
  localparam int WIN_IO  = 1;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_BAR  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pci_win_regs.sv
// Storage for one window: size mask, local base pointer and gated BAR.
module pci_win_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_we,
  input  logic          ptr_we,
  input  logic          bar_we,
  input  logic [AW-1:0] core_data,
  input  logic [AW-1:0] host_data,
  output logic [AW-1:0] mask_q,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] bar_q
);
  logic [AW-1:0] gate_mask;
  logic [AW-1:0] bar_next;

  // A mask written this cycle gates the BAR at once, so stale bits drop out.
  always_comb begin
    gate_mask = mask_we ? core_data : mask_q;
    if (bar_we) bar_next = host_data & gate_mask;
    else        bar_next = bar_q & gate_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ptr_q  <= '0;
      bar_q  <= '0;
    end else begin
      if (mask_we) mask_q <= core_data;
      if (ptr_we)  ptr_q  <= core_data;
      bar_q <= bar_next;
    end
  end
endmodule

// File: rtl/pci_win_match.sv
// Hit detection and address substitution for one window.
module pci_win_match #(
  parameter int AW = 32
) (
  input  logic          req_valid,
  input  logic          type_ok,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] bar,
  input  logic [AW-1:0] ptr,
  output logic          hit,
  output logic [AW-1:0] xlat
);
  logic enabled;
  logic tag_eq;

  always_comb begin
    enabled = |mask;
    tag_eq  = ((addr ^ bar) & mask) == '0;
    hit     = req_valid && type_ok && enabled && tag_eq;
    xlat    = (ptr & mask) | (addr & ~mask);
  end
endmodule

// File: rtl/pci_window_decode.sv
module pci_window_decode #(
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_wr_en,
  input  logic              core_wr_win,
  input  logic              core_wr_ptr,
  input  logic [ADDR_W-1:0] core_wr_data,
  input  logic              host_bar_wr_en,
  input  logic              host_bar_win,
  input  logic [ADDR_W-1:0] host_bar_data,
  input  logic              rd_win,
  input  logic [1:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic              hit_mem,
  output logic              hit_io,
  output logic [ADDR_W-1:0] local_addr
);
  import pci_win_pkg::*;

  logic [ADDR_W-1:0] win_mask [NUM_WIN];
  logic [ADDR_W-1:0] win_ptr  [NUM_WIN];
  logic [ADDR_W-1:0] win_bar  [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0] win_xlat [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel_core;
    logic sel_host;
    logic type_ok;

    assign sel_core = core_wr_en && (core_wr_win == w[0]);
    assign sel_host = host_bar_wr_en && (host_bar_win == w[0]);
    assign type_ok  = (w == WIN_IO) ? req_is_io : !req_is_io;

    pci_win_regs #(.AW(ADDR_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .mask_we   (sel_core && !core_wr_ptr),
      .ptr_we    (sel_core && core_wr_ptr),
      .bar_we    (sel_host),
      .core_data (core_wr_data),
      .host_data (host_bar_data),
      .mask_q    (win_mask[w]),
      .ptr_q     (win_ptr[w]),
      .bar_q     (win_bar[w])
    );

    pci_win_match #(.AW(ADDR_W)) u_match (
      .req_valid (req_valid),
      .type_ok   (type_ok),
      .addr      (req_addr),
      .mask      (win_mask[w]),
      .bar       (win_bar[w]),
      .ptr       (win_ptr[w]),
      .hit       (win_hit[w]),
      .xlat      (win_xlat[w])
    );
  end

  // Only one window can match a given type, so an AND-OR merge is safe.
  logic [ADDR_W-1:0] merged_addr;
  always_comb begin
    merged_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_hit[w]) merged_addr = merged_addr | win_xlat[w];
    end
  end

  if (REG_OUT) begin : g_out_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_mem    <= 1'b0;
        hit_io     <= 1'b0;
        hit        <= 1'b0;
        local_addr <= '0;
      end else begin
        hit_mem    <= win_hit[WIN_MEM];
        hit_io     <= win_hit[WIN_IO];
        hit        <= |win_hit;
        local_addr <= merged_addr;
      end
    end
  end else begin : g_out_comb
    assign hit_mem    = win_hit[WIN_MEM];
    assign hit_io     = win_hit[WIN_IO];
    assign hit        = |win_hit;
    assign local_addr = merged_addr;
  end

  // Registered readback. A BAR is already confined to its mask by the storage.
  logic [ADDR_W-1:0] rd_next;
  always_comb begin
    unique case (rd_sel_e'(rd_sel))
      SEL_MASK: rd_next = win_mask[rd_win];
      SEL_PTR:  rd_next = win_ptr[rd_win];
      SEL_BAR:  rd_next = win_bar[rd_win];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pci_window_decode_chk.sv
module pci_window_decode_chk #(
  parameter int AW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          core_wr_en,
  input logic          core_wr_win,
  input logic          core_wr_ptr,
  input logic          host_bar_wr_en,
  input logic          host_bar_win,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          hit,
  input logic          hit_mem,
  input logic          hit_io,
  input logic [AW-1:0] local_addr,
  input logic [AW-1:0] mem_mask,
  input logic [AW-1:0] mem_bar,
  input logic [AW-1:0] io_mask,
  input logic [AW-1:0] io_bar
);
  assert_single_window_R4: assert property (@(posedge clk) disable iff (rst)
    !(hit_mem && hit_io));

  assert_hit_is_or_R4: assert property (@(posedge clk) disable iff (rst)
    hit == (hit_mem || hit_io));

  // Covers R2 and R7: the BAR never holds bits outside its mask.
  assert_mem_bar_in_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_bar & ~mem_mask) == '0);

  assert_io_bar_in_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (io_bar & ~io_mask) == '0);

  assert_mem_bar_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!(host_bar_wr_en && !host_bar_win) && !(core_wr_en && !core_wr_win && !core_wr_ptr))
      |=> $stable(mem_bar));

  if (REG_OUT) begin : g_lat
    assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(req_valid) |-> !hit);

    assert_zero_mask_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      hit_mem |-> ($past(mem_mask) != '0));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
      hit_mem |-> (((local_addr ^ $past(req_addr)) & ~$past(mem_mask)) == '0));
  end
endmodule

bind pci_window_decode pci_window_decode_chk #(.AW(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .core_wr_en     (core_wr_en),
  .core_wr_win    (core_wr_win),
  .core_wr_ptr    (core_wr_ptr),
  .host_bar_wr_en (host_bar_wr_en),
  .host_bar_win   (host_bar_win),
  .req_valid      (req_valid),
  .req_addr       (req_addr),
  .hit            (hit),
  .hit_mem        (hit_mem),
  .hit_io         (hit_io),
  .local_addr     (local_addr),
  .mem_mask       (win_mask[0]),
  .mem_bar        (win_bar[0]),
  .io_mask        (win_mask[1]),
  .io_bar         (win_bar[1])
);

// File: tb/pci_window_decode_test.sv
`timescale 1ns/1ps
module pci_window_decode_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        core_wr_en, core_wr_win, core_wr_ptr;
  logic [31:0] core_wr_data;
  logic        host_bar_wr_en, host_bar_win;
  logic [31:0] host_bar_data;
  logic        rd_win;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        req_valid, req_is_io;
  logic [31:0] req_addr;
  logic        hit, hit_mem, hit_io;
  logic [31:0] local_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pci_window_decode uut (
    .clk(clk), .rst(rst),
    .core_wr_en(core_wr_en), .core_wr_win(core_wr_win), .core_wr_ptr(core_wr_ptr),
    .core_wr_data(core_wr_data),
    .host_bar_wr_en(host_bar_wr_en), .host_bar_win(host_bar_win),
    .host_bar_data(host_bar_data),
    .rd_win(rd_win), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
    .hit(hit), .hit_mem(hit_mem), .hit_io(hit_io), .local_addr(local_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic core_write(input bit win, input bit ptr, input logic [31:0] d);
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_win = win; core_wr_ptr = ptr; core_wr_data = d;
    @(negedge clk);
    core_wr_en = 1'b0;
  endtask

  task automatic host_write(input bit win, input logic [31:0] d);
    @(negedge clk);
    host_bar_wr_en = 1'b1; host_bar_win = win; host_bar_data = d;
    @(negedge clk);
    host_bar_wr_en = 1'b0;
  endtask

  // Select is set at a falling edge, captured at the rising edge, read at the next fall.
  task automatic read_reg(input bit win, input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_win = win; rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic expect_reg(input bit win, input logic [1:0] sel, input logic [31:0] exp,
                            input string tag);
    logic [31:0] v;
    read_reg(win, sel, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic lookup(input bit valid, input bit io, input logic [31:0] a,
                        input bit exp_mem, input bit exp_io, input logic [31:0] exp_addr,
                        input string tag);
    @(negedge clk);
    req_valid = valid; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(hit_mem == exp_mem && hit_io == exp_io && hit == (exp_mem | exp_io),
          {tag, " hit flags"}, {29'd0, hit, hit_mem, hit_io},
          {29'd0, exp_mem | exp_io, exp_mem, exp_io});
    check(local_addr == exp_addr, {tag, " local_addr"}, local_addr, exp_addr);
  endtask

  task automatic t_reset;
    for (int w = 0; w < 2; w++) begin
      expect_reg(w[0], 2'd0, 32'h0, "R1 mask after reset");
      expect_reg(w[0], 2'd1, 32'h0, "R1 pointer after reset");
      expect_reg(w[0], 2'd2, 32'h0, "R1 BAR after reset");
    end
    lookup(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, "R1 memory lookup after reset");
    lookup(1'b1, 1'b1, 32'h0, 1'b0, 1'b0, 32'h0, "R1 io lookup after reset");
  endtask

  task automatic t_zero_mask;
    host_write(1'b0, 32'hFFFF_FFFF);
    expect_reg(1'b0, 2'd2, 32'h0, "R2 BAR write blocked by zero mask");
    lookup(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, "R3 zero mask never claims");
    expect_reg(1'b0, 2'd3, 32'h0, "R9 select 3 returns zero");
  endtask

  task automatic t_mem_window;
    core_write(1'b0, 1'b0, 32'hFFFF_0000);
    core_write(1'b0, 1'b1, 32'h1234_ABCD);
    host_write(1'b0, 32'hABCD_5678);
    expect_reg(1'b0, 2'd0, 32'hFFFF_0000, "R9 mask readback");
    expect_reg(1'b0, 2'd1, 32'h1234_ABCD, "R6 pointer stored in full");
    expect_reg(1'b0, 2'd2, 32'hABCD_0000, "R2 BAR keeps only writable bits");
    lookup(1'b1, 1'b0, 32'hABCD_0042, 1'b1, 1'b0, 32'h1234_0042, "R5 R6 memory hit");
    lookup(1'b1, 1'b1, 32'hABCD_0042, 1'b0, 1'b0, 32'h0, "R4 io type misses memory window");
    lookup(1'b1, 1'b0, 32'hABCE_0042, 1'b0, 1'b0, 32'h0, "R4 outside window");
    lookup(1'b0, 1'b0, 32'hABCD_0042, 1'b0, 1'b0, 32'h0, "R8 no hit without valid");
  endtask

  task automatic t_io_window;
    core_write(1'b1, 1'b0, 32'hFFFF_FF00);
    host_write(1'b1, 32'h0000_C0FF);
    core_write(1'b1, 1'b1, 32'h00FF_1177);
    expect_reg(1'b1, 2'd2, 32'h0000_C000, "R2 io BAR gated");
    lookup(1'b1, 1'b1, 32'h0000_C01A, 1'b0, 1'b1, 32'h00FF_111A, "R5 io hit");
    lookup(1'b1, 1'b0, 32'hABCD_0000, 1'b1, 1'b0, 32'h1234_0000, "R4 memory still hits");
    lookup(1'b1, 1'b0, 32'h0000_C01A, 1'b0, 1'b0, 32'h0, "R4 memory type misses io window");
  endtask

  task automatic t_mask_change;
    core_write(1'b0, 1'b0, 32'hFF00_0000);
    expect_reg(1'b0, 2'd2, 32'hAB00_0000, "R7 shrink clears BAR bits");
    lookup(1'b1, 1'b0, 32'hAB99_9999, 1'b1, 1'b0, 32'h1299_9999, "R6 narrow window translation");
    core_write(1'b0, 1'b0, 32'hFFFF_0000);
    expect_reg(1'b0, 2'd2, 32'hAB00_0000, "R7 cleared bits stay zero after widening");
    lookup(1'b1, 1'b0, 32'hABCD_0001, 1'b0, 1'b0, 32'h0, "R7 stale range not claimed");
    lookup(1'b1, 1'b0, 32'hAB00_0001, 1'b1, 1'b0, 32'h1234_0001, "R7 new range claimed");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_win = 1'b1; core_wr_ptr = 1'b0; core_wr_data = 32'hF000_0000;
    host_bar_wr_en = 1'b1; host_bar_win = 1'b1; host_bar_data = 32'h5FFF_FFFF;
    @(negedge clk);
    core_wr_en = 1'b0; host_bar_wr_en = 1'b0;
    expect_reg(1'b1, 2'd2, 32'h5000_0000, "R10 BAR gated by new mask");
  endtask

  task automatic t_disable;
    core_write(1'b0, 1'b0, 32'h0);
    expect_reg(1'b0, 2'd2, 32'h0, "R7 zero mask clears BAR");
    lookup(1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, "R3 disabled window quiet");
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    core_wr_en = 1'b0; core_wr_win = 1'b0; core_wr_ptr = 1'b0; core_wr_data = '0;
    host_bar_wr_en = 1'b0; host_bar_win = 1'b0; host_bar_data = '0;
    rd_win = 1'b0; rd_sel = 2'd0;
    req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_mask();
    t_mem_window();
    t_io_window();
    t_mask_change();
    t_same_cycle();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule